// File: doc/BRIEF.md
# Reset Supervisor with Watchdog

This block generates a system reset from three causes: a supply-fail flag that an external comparator has already turned into a digital level, an active-low manual reset request, and a watchdog input that the supervised processor must keep toggling. Each input is synchronised to the system clock before use.

Once every cause has gone away, the reset output stays asserted for a release delay. Software does not control the delay. It is picked from a fixed menu by a select input. The watchdog period is picked the same way, and both are counted in ticks of a prescaler. The prescaler produces one tick per 3.125 ms, derived from the clock-frequency parameter. The polarity of the output is a build parameter. At power-up the block starts in reset and completes a full release delay before it first lets go.

At the board level, the manual reset input should be tied or pulled high when it is unused, so that it reads as inactive.

Top module: `rst_supervisor`

## Requirements
- R1: While `rst_n` is low, and after it rises, reset is asserted. The first deassertion comes only after one full release delay.
- R2: While `supply_fail` is 1, reset is asserted within 3 clock cycles and stays asserted.
- R3: A low level on `mr_n` asserts reset within 3 cycles, in any state, including during a release delay. Reset stays asserted while `mr_n` is low. A high level on `mr_n` is inactive.
- R4: Release delay. The delay starts when the last cause clears. Reset deasserts after N ticks, within a window of N-1 to N ticks plus up to 4 cycles of synchroniser latency. `dly_sel` selects N: 0 gives 512, 1 gives 128, 2 gives 64, 3 gives 32, 4 gives 16, 5 gives 8 and 6 gives 1 (1.6 s down to 3.13 ms). A value of 7 gives 512.
- R5: Watchdog timeout. If `wdi` holds one level, high or low, for M ticks, reset is asserted, within a window of M-1 to M ticks plus 4 cycles. `wdt_sel` selects M: 0 gives 512, 1 gives 128, 2 gives 64, 3 gives 32, 4 gives 16 and 5 gives 2 (1.6 s down to 6.25 ms). Values 6 and 7 give 512.
- R6: Every edge on `wdi`, rising or falling, restarts the watchdog count. Toggling faster than the period never causes a reset.
- R7: The watchdog count is held at zero while reset is asserted. It starts afresh when reset deasserts.
- R8: A watchdog timeout is followed by the same full release delay as any other cause.
- R9: With `ACTIVE_HIGH`=0, `rst_out` is 0 while reset is asserted. With `ACTIVE_HIGH`=1, it is 1 while reset is asserted.
- R10: One tick equals CLK_HZ/320 clock cycles, which is 3.125 ms.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| supply_fail | input | 1 | Digitised supply-fail flag, active high |
| mr_n | input | 1 | Manual reset request, active low |
| wdi | input | 1 | Watchdog service input, toggled by the processor |
| wdt_sel | input | 3 | Watchdog period select |
| dly_sel | input | 3 | Release delay select |
| rst_out | output | 1 | Reset output, polarity set by ACTIVE_HIGH |

## Verification
The assertions check four things on every cycle. An active supply-fail or manual-reset level forces reset on the next cycle. Reset is released only on a tick. The delay counter sits idle outside reset. The watchdog count is cleared while reset is held.

Some behaviour depends on time, and only the bench scenarios can show it. This covers the length of each delay and timeout in the menus, restart of the delay by a late manual reset, servicing by edges of either direction, and the fresh watchdog count after release. The bench measures these as windows of cycles, because the tick phase is free-running.

// File: rtl/rst_supervisor.sv
module rst_supervisor #(
  parameter int CLK_HZ      = 250_000_000,
  parameter bit ACTIVE_HIGH = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_fail,
  input  logic       mr_n,
  input  logic       wdi,
  input  logic [2:0] wdt_sel,
  input  logic [2:0] dly_sel,
  output logic       rst_out
);
  localparam int TICK_CYCLES = (CLK_HZ / 320 < 2) ? 2 : CLK_HZ / 320;
  localparam int PW = $clog2(TICK_CYCLES);
  localparam int CW = 10;

  function automatic logic [CW-1:0] wd_ticks(input logic [2:0] s);
    case (s)
      3'd1: wd_ticks = 10'd128;
      3'd2: wd_ticks = 10'd64;
      3'd3: wd_ticks = 10'd32;
      3'd4: wd_ticks = 10'd16;
      3'd5: wd_ticks = 10'd2;
      default: wd_ticks = 10'd512;
    endcase
  endfunction

  function automatic logic [CW-1:0] dly_ticks(input logic [2:0] s);
    case (s)
      3'd1: dly_ticks = 10'd128;
      3'd2: dly_ticks = 10'd64;
      3'd3: dly_ticks = 10'd32;
      3'd4: dly_ticks = 10'd16;
      3'd5: dly_ticks = 10'd8;
      3'd6: dly_ticks = 10'd1;
      default: dly_ticks = 10'd512;
    endcase
  endfunction

  logic [1:0]    mr_q, fail_q, wd_q;
  logic          wd_prev;
  logic [PW-1:0] pcnt;
  logic [CW-1:0] dcnt, wcnt;
  logic          asserted;

  wire mr_s    = mr_q[1];
  wire fail_s  = fail_q[1];
  wire wd_s    = wd_q[1];
  wire tick    = (pcnt == PW'(TICK_CYCLES - 1));
  wire wd_edge = wd_s ^ wd_prev;
  wire cause   = fail_s | ~mr_s;
  wire [CW-1:0] wlen = wd_ticks(wdt_sel);
  wire [CW-1:0] dlen = dly_ticks(dly_sel);
  wire wd_trip = ~asserted & tick & ~wd_edge & (wcnt >= wlen - 10'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mr_q    <= 2'b11;
      fail_q  <= 2'b00;
      wd_q    <= 2'b00;
      wd_prev <= 1'b0;
    end else begin
      mr_q    <= {mr_q[0], mr_n};
      fail_q  <= {fail_q[0], supply_fail};
      wd_q    <= {wd_q[0], wdi};
      wd_prev <= wd_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt <= '0;
    else        pcnt <= tick ? '0 : pcnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      asserted <= 1'b1;
      dcnt     <= '0;
    end else if (cause || wd_trip) begin
      asserted <= 1'b1;
      dcnt     <= '0;
    end else if (asserted && tick) begin
      if (dcnt >= dlen - 10'd1) begin
        asserted <= 1'b0;
        dcnt     <= '0;
      end else begin
        dcnt <= dcnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           wcnt <= '0;
    else if (asserted || wd_edge || wd_trip) wcnt <= '0;
    else if (tick)                        wcnt <= wcnt + 1'b1;
  end

  assign rst_out = ACTIVE_HIGH ? asserted : ~asserted;

  a_r2_fail_forces_reset: assert property (@(posedge clk) disable iff (!rst_n)
    fail_s |=> asserted);
  a_r3_manual_forces_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !mr_s |=> asserted);
  a_r4_release_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(asserted) |-> $past(tick));
  a_r4_delay_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !asserted |-> dcnt == '0);
  a_r5_trip_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(asserted) && $past(mr_s) && !$past(fail_s)) |-> $past(tick));
  a_r7_wd_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    asserted |=> wcnt == '0);
endmodule

// File: tb/rst_supervisor_bench.sv
module rst_supervisor_bench;
  localparam int T = 8;
  localparam int CLK_HZ = 320 * T;

  logic clk = 1'b0, rst_n = 1'b0;
  logic supply_fail = 1'b0, mr_n = 1'b1, wdi = 1'b0;
  logic [2:0] wdt_sel = 3'd0, dly_sel = 3'd5;
  logic rst_lo, rst_hi;
  int nvec = 0, nerr = 0;
  bit wd_run = 1'b1;
  int wd_gap = 40;

  rst_supervisor #(.CLK_HZ(CLK_HZ), .ACTIVE_HIGH(1'b0)) u_rst_supervisor (
    .clk, .rst_n, .supply_fail, .mr_n, .wdi, .wdt_sel, .dly_sel, .rst_out(rst_lo));
  rst_supervisor #(.CLK_HZ(CLK_HZ), .ACTIVE_HIGH(1'b1)) u_rst_supervisor_hi (
    .clk, .rst_n, .supply_fail, .mr_n, .wdi, .wdt_sel, .dly_sel, .rst_out(rst_hi));

  always #2 clk = ~clk;

  initial begin
    int c = 0;
    forever begin
      @(negedge clk);
      if (wd_run) begin
        c++;
        if (c >= wd_gap) begin c = 0; wdi = ~wdi; end
      end else c = 0;
    end
  end

  function automatic int dly_n(input int s);
    case (s) 1: return 128; 2: return 64; 3: return 32; 4: return 16;
      5: return 8; 6: return 1; default: return 512; endcase
  endfunction
  function automatic int wd_n(input int s);
    case (s) 1: return 128; 2: return 64; 3: return 32; 4: return 16;
      5: return 2; default: return 512; endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_lvl(input bit want_asserted, input int limit, output int n);
    n = 0;
    while ((rst_lo == 1'b0) != want_asserted && n < limit) begin
      @(negedge clk); n++;
    end
  endtask

  task automatic chk_window(input string req, input int n, input int ticks);
    chk(n >= (ticks - 1) * T && n <= ticks * T + 4, req, n, ticks * T);
  endtask

  task automatic chk_state(input string req, input bit exp_asserted);
    chk(rst_lo == ~exp_asserted, req, int'(rst_lo), int'(~exp_asserted));
    chk(rst_hi == exp_asserted, "R9 active-high polarity", int'(rst_hi), int'(exp_asserted));
  endtask

  task automatic t_powerup();
    int n;
    dly_sel = 3'd5;
    cyc(5);
    chk_state("R1 asserted during rst_n", 1'b1);
    rst_n = 1'b1;
    wait_lvl(1'b0, 300, n);
    chk_window("R1 R10 power-up delay", n, 8);
    chk_state("R9 low polarity released", 1'b0);
  endtask

  task automatic t_fail();
    int n;
    dly_sel = 3'd4;
    supply_fail = 1'b1;
    cyc(3);
    chk_state("R2 supply fail asserts", 1'b1);
    cyc(20);
    chk_state("R2 held while fail", 1'b1);
    supply_fail = 1'b0;
    wait_lvl(1'b0, 400, n);
    chk_window("R4 delay after fail", n, 16);
  endtask

  task automatic t_manual();
    int n;
    dly_sel = 3'd6;
    cyc(20);
    chk_state("R3 mr_n high inactive", 1'b0);
    mr_n = 1'b0;
    cyc(3);
    chk_state("R3 manual asserts", 1'b1);
    mr_n = 1'b1;
    wait_lvl(1'b0, 100, n);
    chk_window("R4 shortest delay", n, 1);
    dly_sel = 3'd3;
    mr_n = 1'b0; cyc(5); mr_n = 1'b1;
    cyc(100);
    chk_state("R3 still in delay", 1'b1);
    mr_n = 1'b0; cyc(3);
    chk_state("R3 manual during delay", 1'b1);
    cyc(2); mr_n = 1'b1;
    wait_lvl(1'b0, 600, n);
    chk_window("R3 R4 delay restarted", n, 32);
  endtask

  task automatic t_dly_menu();
    int n;
    for (int s = 0; s < 8; s++) begin
      dly_sel = 3'(s);
      supply_fail = 1'b1; cyc(4); supply_fail = 1'b0;
      wait_lvl(1'b0, 5000, n);
      chk_window($sformatf("R4 dly_sel=%0d", s), n, dly_n(s));
    end
  endtask

  task automatic t_wd_service();
    int hits = 0;
    wdt_sel = 3'd4;
    wd_gap = 100;
    wd_run = 1'b1;
    for (int i = 0; i < 1200; i++) begin
      @(negedge clk);
      if (rst_lo == 1'b0) hits++;
    end
    chk(hits == 0, "R6 both edges service watchdog", hits, 0);
    wd_gap = 40;
  endtask

  task automatic t_wd_stuck(input bit lvl);
    int n;
    wdt_sel = 3'd4;
    dly_sel = 3'd5;
    wd_run = 1'b0;
    @(negedge clk);
    wdi = ~lvl; cyc(30);
    wdi = lvl;
    wait_lvl(1'b1, 400, n);
    chk_window($sformatf("R5 stuck at %0d", lvl), n, 16);
    wait_lvl(1'b0, 200, n);
    chk_window("R8 delay after timeout", n, 8);
    wd_run = 1'b1;
    cyc(5);
    wait_lvl(1'b0, 400, n);
  endtask

  task automatic t_wd_menu();
    int n;
    dly_sel = 3'd6;
    for (int k = 0; k < 2; k++) begin
      int s = (k == 0) ? 5 : 7;
      wdt_sel = 3'(s);
      wd_run = 1'b0;
      @(negedge clk);
      wdi = ~wdi;
      wait_lvl(1'b1, 5000, n);
      chk_window($sformatf("R5 wdt_sel=%0d", s), n, wd_n(s));
      wd_run = 1'b1;
      wait_lvl(1'b0, 100, n);
    end
    wdt_sel = 3'd0;
  endtask

  task automatic t_wd_fresh();
    int n;
    wdt_sel = 3'd5;
    dly_sel = 3'd3;
    wd_run = 1'b0;
    supply_fail = 1'b1; cyc(4); supply_fail = 1'b0;
    wait_lvl(1'b0, 600, n);
    chk_window("R4 delay 32", n, 32);
    wait_lvl(1'b1, 100, n);
    chk(n >= 6 && n <= 20, "R7 fresh watchdog count after release", n, 2 * T);
    wd_run = 1'b1;
    wdt_sel = 3'd0;
    dly_sel = 3'd6;
    wait_lvl(1'b0, 100, n);
  endtask

  initial begin
    t_powerup();
    t_fail();
    t_manual();
    t_dly_menu();
    t_wd_service();
    t_wd_stuck(1'b1);
    t_wd_stuck(1'b0);
    t_wd_menu();
    t_wd_fresh();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule